// File: doc/BRIEF.md
# Two-Port Interrupt Aggregation Registers

This block gathers interrupt events from two storage ports and folds them into one level-sensitive interrupt line for the host. Each port owns a status register in which single-cycle event pulses are caught and held until software clears them by writing ones, and a mask register that decides which held events count as pending. A host-level status register summarises the ports and a software interrupt source. A host-level mask register picks which of those summaries drive the global pending flag. A host control register can switch the output line off as a whole, keeps a page-select bit, and starts a controller soft reset.

Software reaches every register through a plain register bus: an address, a write strobe, write data, and combinational read data for the current address. The soft reset runs from a two-state sequencer. State SEQ_IDLE moves to SEQ_HOLD when host control is written with the reset bit set (transition "start"). SEQ_HOLD counts down for a fixed number of clocks and then returns to SEQ_IDLE (transition "expire"). While the sequencer sits in SEQ_HOLD the reset bit reads as one, so polling software sees it drop once the reset has finished.

Register addresses: host control 0x00, host status 0x02, host mask 0x04. Port p has its status register at 0x40 + 0x10*p and its mask register at 0x41 + 0x10*p. Any other address reads zero and ignores writes.

Top module: `dual_port_irq_regs`

## Requirements
- R1: An event pulse on port event bit i (bit0 device removed, bit1 device attached, bit2 command done, bit3 fatal error, bit4 device interrupt, bit5 reply queue not empty) sets port status bit i on the next clock edge, whether or not that bit is masked. The bit stays set until it is cleared.
- R2: A write to a port status register clears every bit 0..5 for which the write data holds a one and leaves the others unchanged. Writing 0xFF clears all held events.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit remains set.
- R4: Port status bit 7 reads as the OR of (status bits 0..5 AND NOT mask bits 0..5). Bit 7 and bit 6 are not writable. The port mask register stores bits 0..5, and bits 6..15 read zero. Writing 0xFF to the mask masks every event, so bit 7 reads zero.
- R5: Host status bit p (p = 0, 1) reads port p's pending bit. Host status bit 15 reads the OR of host status bits 0, 1 and 14, each ANDed with NOT the matching host mask bit. Host status bits 0, 1 and 15 are read-only.
- R6: Writing host control with bit 14 set raises the software interrupt, which reads as host status bit 14. Writing host status with bit 14 set clears it. Host control bit 14 itself reads zero.
- R7: irq_o is host status bit 15 AND NOT host control bit 8 (global interrupt off). Bit 8 is written by every host-control write.
- R8: Writing host control with bit 13 set, while no soft reset is running, makes bit 13 read one for exactly RST_CYCLES (default 3) cycles and then zero. During those cycles all port status bits and the software interrupt are held clear, incoming events are dropped, port masks are forced to all ones and port register writes are ignored. Host control bits 8 and 15 and the host mask are not affected.
- R9: After rst_n, port status registers read 0x0000, port masks read 0x003F, host control reads 0x0100, host status reads 0x0000, host mask reads 0x4003 and irq_o is low.
- R10: Host control bit 15 (page select) stores the value written and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_PORTS*EVT_W | Event pulses, port p in bits [p*EVT_W +: EVT_W] |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The directed part first sets single events under full masking, then removes the mask, which tells latching apart from pending. Clearing writes with partial data separate a bit-wise clear from a register-wide one. A clear and an event on the same bit in the same cycle show which one wins. A soft reset issued with events arriving and port writes in flight shows what the sequencer clears, what it drops and what it leaves alone, and over how many cycles. A long pseudo-random mix of events, writes to every register and reads of every address, including an unmapped one, is then compared on every clock against a behavioural model. This catches interactions between the masks, the summary levels and the global off bit that the directed cases do not combine.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    // host control bit positions
    localparam int HCTL_OFF_BIT  = 8;
    localparam int HCTL_SRST_BIT = 13;
    localparam int HCTL_SWI_BIT  = 14;
    localparam int HCTL_PAGE_BIT = 15;

    // host status / mask bit positions
    localparam int HST_SWI_BIT  = 14;
    localparam int HST_GLOB_BIT = 15;

    // port status summary bit
    localparam int PST_PEND_BIT = 7;

    // register addresses
    localparam logic [7:0] ADDR_HCTL      = 8'h00;
    localparam logic [7:0] ADDR_HST       = 8'h02;
    localparam logic [7:0] ADDR_HMASK     = 8'h04;
    localparam logic [7:0] ADDR_PORT_BASE = 8'h40;
    localparam logic [7:0] PORT_STRIDE    = 8'h10;

    function automatic logic [7:0] port_reg_addr(input int p, input logic is_mask);
        return ADDR_PORT_BASE + 8'(p) * PORT_STRIDE + {7'd0, is_mask};
    endfunction

endpackage

// File: rtl/irqagg_port.sv
module irqagg_port #(
    parameter int EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             st_wr_i,
    input  logic             mk_wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [EVT_W-1:0] status_o,
    output logic [EVT_W-1:0] mask_o,
    output logic             pending_o
);

    logic [EVT_W-1:0] stat_q;
    logic [EVT_W-1:0] mask_q;
    logic [EVT_W-1:0] clr_bits;

    always_comb begin
        clr_bits = st_wr_i ? wdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else if (clear_i) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt_i;
            if (mk_wr_i) begin
                mask_q <= wdata_i;
            end
        end
    end

    assign status_o  = stat_q;
    assign mask_o    = mask_q;
    assign pending_o = |(stat_q & ~mask_q);

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !st_wr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R2
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_i && !clear_i) |=> ((stat_q & $past(wdata_i & ~evt_i)) == '0));

    // R3
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && (|evt_i)) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ((stat_q == '0) && (mask_q == '1)));

endmodule

// File: rtl/irqagg_rst_seq.sv
module irqagg_rst_seq
    import irqagg_pkg::*;
#(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_i)       state_d = SEQ_HOLD;  // start
            SEQ_HOLD: if (cnt_q == '0)   state_d = SEQ_IDLE;  // expire
            default:                     state_d = SEQ_IDLE;
        endcase
    end

    // hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == SEQ_IDLE && start_i) begin
            cnt_q <= CNT_LOAD;
        end else if (state_q == SEQ_HOLD && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: busy_o = 1'b0;
            SEQ_HOLD: busy_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    // R8
    seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start_i) |=> (busy_o && cnt_q == CNT_LOAD));

    // R8
    seq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

    // R8
    seq_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == '0) |=> !busy_o);

endmodule

// File: rtl/irqagg_host.sv
module irqagg_host
    import irqagg_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic [NUM_PORTS-1:0] port_pend_i,
    input  logic                 ctrl_wr_i,
    input  logic                 stat_wr_i,
    input  logic                 mask_wr_i,
    input  logic [15:0]          wdata_i,
    output logic                 srst_req_o,
    output logic [15:0]          ctrl_rd_o,
    output logic [15:0]          stat_rd_o,
    output logic [15:0]          mask_rd_o,
    output logic                 irq_o
);

    logic                 irq_off_q;
    logic                 page_q;
    logic                 soft_q;
    logic [NUM_PORTS-1:0] pmask_q;
    logic                 smask_q;
    logic                 glob;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_off_q <= 1'b1;
            page_q    <= 1'b0;
            pmask_q   <= '1;
            smask_q   <= 1'b1;
        end else begin
            if (ctrl_wr_i) begin
                irq_off_q <= wdata_i[HCTL_OFF_BIT];
                page_q    <= wdata_i[HCTL_PAGE_BIT];
            end
            if (mask_wr_i) begin
                pmask_q <= wdata_i[NUM_PORTS-1:0];
                smask_q <= wdata_i[HST_SWI_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (clear_i) begin
            soft_q <= 1'b0;
        end else if (ctrl_wr_i && wdata_i[HCTL_SWI_BIT]) begin
            soft_q <= 1'b1;
        end else if (stat_wr_i && wdata_i[HST_SWI_BIT]) begin
            soft_q <= 1'b0;
        end
    end

    assign glob       = (|(port_pend_i & ~pmask_q)) | (soft_q & ~smask_q);
    assign irq_o      = glob & ~irq_off_q;
    assign srst_req_o = ctrl_wr_i & wdata_i[HCTL_SRST_BIT];

    always_comb begin
        ctrl_rd_o                = '0;
        ctrl_rd_o[HCTL_OFF_BIT]  = irq_off_q;
        ctrl_rd_o[HCTL_SRST_BIT] = clear_i;
        ctrl_rd_o[HCTL_PAGE_BIT] = page_q;

        stat_rd_o                  = '0;
        stat_rd_o[NUM_PORTS-1:0]   = port_pend_i;
        stat_rd_o[HST_SWI_BIT]     = soft_q;
        stat_rd_o[HST_GLOB_BIT]    = glob;

        mask_rd_o                = '0;
        mask_rd_o[NUM_PORTS-1:0] = pmask_q;
        mask_rd_o[HST_SWI_BIT]   = smask_q;
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_off_q |-> !irq_o);

    // R6
    swi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && wdata_i[HCTL_SWI_BIT] && !clear_i) |=> soft_q);

    // R10
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_i |=> $stable(page_q));

endmodule

// File: rtl/dual_port_irq_regs.sv
module dual_port_irq_regs
    import irqagg_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int EVT_W      = 6,
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*EVT_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [15:0]                bus_wdata,
    output logic [15:0]                bus_rdata,
    output logic                       irq_o
);

    logic                 busy;
    logic                 srst_req;
    logic [NUM_PORTS-1:0] pend;
    logic [NUM_PORTS-1:0] st_sel;
    logic [NUM_PORTS-1:0] mk_sel;
    logic [EVT_W-1:0]     pstat [NUM_PORTS];
    logic [EVT_W-1:0]     pmask [NUM_PORTS];
    logic [15:0]          ctrl_rd, stat_rd, mask_rd;
    logic                 hit_ctrl, hit_stat, hit_mask;

    assign hit_ctrl = (bus_addr == ADDR_W'(ADDR_HCTL));
    assign hit_stat = (bus_addr == ADDR_W'(ADDR_HST));
    assign hit_mask = (bus_addr == ADDR_W'(ADDR_HMASK));

    irqagg_rst_seq #(
        .RST_CYCLES(RST_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(srst_req),
        .busy_o (busy)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(port_reg_addr(p, 1'b0));
        localparam logic [ADDR_W-1:0] MK_ADDR = ADDR_W'(port_reg_addr(p, 1'b1));

        assign st_sel[p] = bus_wr && (bus_addr == ST_ADDR);
        assign mk_sel[p] = bus_wr && (bus_addr == MK_ADDR);

        irqagg_port #(
            .EVT_W(EVT_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (busy),
            .evt_i    (evt_i[p*EVT_W +: EVT_W]),
            .st_wr_i  (st_sel[p]),
            .mk_wr_i  (mk_sel[p]),
            .wdata_i  (bus_wdata[EVT_W-1:0]),
            .status_o (pstat[p]),
            .mask_o   (pmask[p]),
            .pending_o(pend[p])
        );
    end

    irqagg_host #(
        .NUM_PORTS(NUM_PORTS)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (busy),
        .port_pend_i(pend),
        .ctrl_wr_i  (bus_wr && hit_ctrl),
        .stat_wr_i  (bus_wr && hit_stat),
        .mask_wr_i  (bus_wr && hit_mask),
        .wdata_i    (bus_wdata),
        .srst_req_o (srst_req),
        .ctrl_rd_o  (ctrl_rd),
        .stat_rd_o  (stat_rd),
        .mask_rd_o  (mask_rd),
        .irq_o      (irq_o)
    );

    always_comb begin
        logic [15:0] word;
        bus_rdata = '0;
        word      = '0;
        if (hit_ctrl) begin
            bus_rdata = ctrl_rd;
        end else if (hit_stat) begin
            bus_rdata = stat_rd;
        end else if (hit_mask) begin
            bus_rdata = mask_rd;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_addr == ADDR_W'(port_reg_addr(p, 1'b0))) begin
                    word               = 16'(pstat[p]);
                    word[PST_PEND_BIT] = pend[p];
                    bus_rdata          = word;
                end else if (bus_addr == ADDR_W'(port_reg_addr(p, 1'b1))) begin
                    bus_rdata = 16'(pmask[p]);
                end
            end
        end
    end

    // R8
    srst_clears_swi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (stat_rd[HST_SWI_BIT] == 1'b0));

    // R5
    host_pend_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd[NUM_PORTS-1:0] == pend);

endmodule

// File: tb/dual_port_irq_regs_bench.sv
`timescale 1ns/1ps
module dual_port_irq_regs_bench;

    localparam int RSTC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int mst[2];
    int mmk[2];
    int msoft, mhmask, moff, mpage, mleft;

    always #5 clk = ~clk;

    dual_port_irq_regs u_dual_port_irq_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    function automatic int pend_of(input int p);
        return ((mst[p] & ~mmk[p] & 'h3F) != 0) ? 1 : 0;
    endfunction

    function automatic int glob_of();
        int g;
        g = 0;
        if (pend_of(0) != 0 && (mhmask & 'h1) == 0) g = 1;
        if (pend_of(1) != 0 && (mhmask & 'h2) == 0) g = 1;
        if (msoft != 0 && (mhmask & 'h4000) == 0) g = 1;
        return g;
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            'h00: return (moff << 8) | ((mleft > 0 ? 1 : 0) << 13) | (mpage << 15);
            'h02: return pend_of(0) | (pend_of(1) << 1) | (msoft << 14) | (glob_of() << 15);
            'h04: return mhmask;
            'h40: return mst[0] | (pend_of(0) << 7);
            'h41: return mmk[0];
            'h50: return mst[1] | (pend_of(1) << 7);
            'h51: return mmk[1];
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        mst[0] = 0; mst[1] = 0;
        mmk[0] = 'h3F; mmk[1] = 'h3F;
        msoft = 0; mhmask = 'h4003; moff = 1; mpage = 0; mleft = 0;
    endtask

    task automatic model_edge(input int e0, input int e1, input int wr, input int a, input int d);
        bit busy;
        int ev[2];
        busy = (mleft > 0);
        ev[0] = e0; ev[1] = e1;
        for (int p = 0; p < 2; p++) begin
            int clr;
            if (busy) begin
                mst[p] = 0;
                mmk[p] = 'h3F;
            end else begin
                clr = (wr != 0 && a == ('h40 + 'h10 * p)) ? (d & 'h3F) : 0;
                mst[p] = (mst[p] & ~clr) | (ev[p] & 'h3F);
                if (wr != 0 && a == ('h41 + 'h10 * p)) mmk[p] = d & 'h3F;
            end
        end
        if (busy) msoft = 0;
        else if (wr != 0 && a == 'h00 && (d & 'h4000) != 0) msoft = 1;
        else if (wr != 0 && a == 'h02 && (d & 'h4000) != 0) msoft = 0;
        if (wr != 0 && a == 'h00) begin
            moff = (d >> 8) & 1;
            mpage = (d >> 15) & 1;
        end
        if (wr != 0 && a == 'h04) mhmask = d & 'h4003;
        if (busy) mleft = mleft - 1;
        else if (wr != 0 && a == 'h00 && (d & 'h2000) != 0) mleft = RSTC;
    endtask

    // one clock: drive, compare read data and irq against model, advance model
    task automatic step(input int e0, input int e1, input int wr, input int a, input int d,
                        input string tag);
        int er, ei;
        @(negedge clk);
        evt_i[5:0]  = 6'(e0);
        evt_i[11:6] = 6'(e1);
        bus_wr      = (wr != 0);
        bus_addr    = 8'(a);
        bus_wdata   = 16'(d);
        #1;
        er = exp_read(a);
        ei = (glob_of() != 0 && moff == 0) ? 1 : 0;
        checks++;
        if (bus_rdata !== 16'(er) || irq_o !== 1'(ei)) begin
            failures++;
            $display("FAIL %s addr=%02h rdata=%04h exp=%04h irq=%0b exp=%0d",
                     tag, a, bus_rdata, 16'(er), irq_o, ei);
        end
        @(posedge clk);
        model_edge(e0, e1, wr, a, d);
    endtask

    task automatic rd(input int a, input string tag);
        step(0, 0, 0, a, 0, tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(0, 0, 1, a, d, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values
        rd('h00, "R9"); rd('h02, "R9"); rd('h04, "R9");
        rd('h40, "R9"); rd('h41, "R9"); rd('h50, "R9"); rd('h51, "R9");

        // R1: events latch while fully masked
        step('h05, 0, 0, 'h40, 0, "R1");
        rd('h40, "R1");
        step(0, 'h30, 0, 'h50, 0, "R1");
        rd('h50, "R1");
        rd('h02, "R1");

        // R4: unmask to see pending; full mask removes it; bit7 not writable
        wr('h41, 'h3B, "R4");
        rd('h40, "R4");
        rd('h41, "R4");
        wr('h41, 'hFF, "R4");
        rd('h40, "R4");
        rd('h41, "R4");
        wr('h41, 'h3B, "R4");
        wr('h40, 'h80, "R4");
        rd('h40, "R4");

        // R5: host summary and read-only bits
        wr('h04, 'h4002, "R5");
        rd('h02, "R5");
        wr('h02, 'h8003, "R5");
        rd('h02, "R5");

        // R7: global off gates the output
        rd('h02, "R7");
        wr('h00, 'h0000, "R7");
        rd('h02, "R7");
        wr('h00, 'h0100, "R7");
        rd('h00, "R7");
        wr('h00, 'h0000, "R7");

        // R2: bit-wise clear, then clear all
        wr('h40, 'h01, "R2");
        rd('h40, "R2");
        step('h3F, 0, 0, 'h40, 0, "R2");
        rd('h40, "R2");
        wr('h40, 'hFF, "R2");
        rd('h40, "R2");

        // R3: event and clear on the same bit, same cycle
        step('h04, 0, 0, 'h40, 0, "R3");
        step('h04, 0, 1, 'h40, 'h04, "R3");
        rd('h40, "R3");
        step('h02, 0, 1, 'h40, 'h06, "R3");
        rd('h40, "R3");

        // R6: software interrupt set, unmask, clear
        wr('h00, 'h4000, "R6");
        rd('h02, "R6");
        rd('h00, "R6");
        wr('h04, 'h0003, "R6");
        rd('h02, "R6");
        wr('h02, 'h4000, "R6");
        rd('h02, "R6");

        // R10: page select
        wr('h00, 'h8000, "R10");
        rd('h00, "R10");
        wr('h00, 'h0000, "R10");
        rd('h00, "R10");

        // R8: soft reset with events, port writes and host writes in flight
        step('h1F, 'h2A, 0, 'h40, 0, "R8");
        wr('h51, 'h00, "R8");
        wr('h00, 'h4000, "R8");
        wr('h00, 'h2000, "R8");
        step('h01, 'h02, 0, 'h00, 0, "R8");
        step(0, 0, 1, 'h41, 'h00, "R8");
        step('h08, 0, 1, 'h00, 'h8100, "R8");
        rd('h00, "R8");
        rd('h40, "R8"); rd('h41, "R8"); rd('h50, "R8"); rd('h51, "R8");
        rd('h02, "R8"); rd('h04, "R8"); rd('h00, "R8");
        wr('h00, 'h2000, "R8");
        wr('h00, 'h2000, "R8");
        rd('h00, "R8"); rd('h00, "R8"); rd('h00, "R8");

        // R5: long mixed traffic compared on every clock
        for (int i = 0; i < 4000; i++) begin
            int sel, a, d, w, e0, e1;
            sel = int'($urandom % 8);
            case (sel)
                0: a = 'h00; 1: a = 'h02; 2: a = 'h04; 3: a = 'h40;
                4: a = 'h41; 5: a = 'h50; 6: a = 'h51; default: a = 'h07;
            endcase
            w  = (($urandom % 3) == 0) ? 1 : 0;
            d  = int'($urandom & 'hFFFF);
            if (a == 'h00 && (($urandom % 4) != 0)) d = d & ~'h2000;
            e0 = (($urandom % 4) == 0) ? int'($urandom & 'h3F) : 0;
            e1 = (($urandom % 4) == 0) ? int'($urandom & 'h3F) : 0;
            step(e0, e1, w, a, d, "R5");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule